// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects up to 32 peripheral request lines and routes each one into one of three classes. Lines in the fast class are ORed into a single fast-interrupt output. Lines claimed by one of 16 programmable vector slots form the vectored class. Every remaining line is non-vectored. The vectored and non-vectored classes together drive a normal-interrupt output.

The block presents a vector address. It is the address held by the highest-priority slot that is eligible, or a programmable default address when no slot is eligible. When the processor reads this address through the register bus, the winning slot is marked in service. Slots of equal or lower priority stay hidden until an end-of-interrupt write releases that slot. Higher-priority slots can still preempt.

All configuration and status use a simple synchronous word-addressed bus. A read returns its data one cycle after the request.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the mask, fast-class, default-vector and slot registers are zero, both interrupt outputs are low, and nothing is in service.
- R2: Global mask (word 0x01) gates every line before classification. Word 0x00 reads the raw request lines. Word 0x04 reads raw AND mask. A masked line affects neither output.
- R3: A line whose bit is set in the fast-class register (word 0x02) drives fiq_o when it is unmasked and requesting. fiq_o is the OR of all such lines. A fast-class line never raises irq_o.
- R4: Word 0x03 reads the set of unmasked fast-class lines that are currently requesting, one bit per line.
- R5: irq_o is the OR of all unmasked requesting lines that are not in the fast class, whether vectored or non-vectored.
- R6: Slot k has a control word at 0x10+k and a vector address at 0x20+k. In the control word, bits 4:0 pick the source line and bit 5 enables the slot. A disabled slot never matches. A slot whose source is in the fast class never matches.
- R7: vec_addr_o shows the address of the lowest-numbered matching slot that is eligible. Slot 0 has the highest priority. When no slot is eligible, vec_addr_o shows the default vector (word 0x05).
- R8: Reading word 0x06 returns the presented address. If a slot was the winner, that slot is marked in service. Slots numbered at or above the lowest in-service slot are then not eligible. A read made when no slot is eligible marks nothing.
- R9: Any write to word 0x07 releases the lowest-numbered in-service slot. When nothing is in service, the write has no effect.
- R10: Writable registers read back their written values. Read data appears on the clock edge after the read request and holds while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src_i | input | NUM_SRC | Level request lines from peripherals |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 8 | Word address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, one cycle after the read strobe |
| fiq_o | output | 1 | Fast-interrupt request to the processor |
| irq_o | output | 1 | Normal-interrupt request to the processor |
| vec_addr_o | output | ADDR_W | Currently presented vector address |

## Verification
The bench sweeps every source line through the fast class, the masked state and the normal class. A design that leaked fast-class lines into irq_o, or that applied the mask after the fast OR, fails within one line of the sweep. It drives all slot sources together and then drops the highest-priority one at a time. A reversed or off-by-one priority encoder shows up there as the wrong address. The bench also covers three cases that should give the default vector instead of a slot address: a disabled slot, a fast-class source mapped onto a slot, and a lookup that misses. A nested claim followed by release sequences checks that end-of-interrupt frees the innermost slot rather than the outermost. It also checks that an empty read leaves no slot stuck in service.

// File: rtl/vic_pkg.sv
`timescale 1ns/1ps
package vic_pkg;
   localparam logic [7:0] A_RAW       = 8'h00;
   localparam logic [7:0] A_MASK      = 8'h01;
   localparam logic [7:0] A_FAST      = 8'h02;
   localparam logic [7:0] A_FSTAT     = 8'h03;
   localparam logic [7:0] A_MSTAT     = 8'h04;
   localparam logic [7:0] A_DFLT      = 8'h05;
   localparam logic [7:0] A_VEC       = 8'h06;
   localparam logic [7:0] A_EOI       = 8'h07;
   localparam logic [3:0] A_CTRL_PAGE = 4'h1;
   localparam logic [3:0] A_ADDR_PAGE = 4'h2;

   typedef enum logic [1:0] {
      CLS_FAST  = 2'd0,
      CLS_VECT  = 2'd1,
      CLS_PLAIN = 2'd2
   } src_class_e;
endpackage

// File: rtl/vic_slot_match.sv
`timescale 1ns/1ps
module vic_slot_match #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned SW      = 5
) (
   input  logic               en_i,
   input  logic [SW-1:0]      sel_i,
   input  logic [NUM_SRC-1:0] cand_i,
   output logic               hit_o
);
   always_comb begin
      hit_o = 1'b0;
      if (en_i && (32'(sel_i) < NUM_SRC)) begin
         hit_o = cand_i[sel_i];
      end
   end
endmodule

// File: rtl/vic_prio_pick.sv
`timescale 1ns/1ps
module vic_prio_pick #(
   parameter int unsigned N  = 16,
   parameter int unsigned IW = 4
) (
   input  logic [N-1:0]  act_i,
   input  logic [N-1:0]  busy_i,
   output logic [N-1:0]  grant_o,
   output logic [IW-1:0] idx_o,
   output logic          valid_o
);
   logic blocked;

   always_comb begin
      blocked = 1'b0;
      grant_o = '0;
      idx_o   = '0;
      valid_o = 1'b0;
      for (int k = 0; k < N; k++) begin
         blocked = blocked | busy_i[k];
         if (!valid_o && act_i[k] && !blocked) begin
            valid_o    = 1'b1;
            grant_o[k] = 1'b1;
            idx_o      = IW'(k);
         end
      end
   end
endmodule

// File: rtl/vic_inservice.sv
`timescale 1ns/1ps
module vic_inservice #(
   parameter int unsigned N  = 16,
   parameter int unsigned IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_i,
   input  logic [IW-1:0] set_idx_i,
   input  logic          rel_i,
   output logic [N-1:0]  busy_o
);
   logic [N-1:0] lowest;
   logic [N-1:0] busy_nxt;

   always_comb begin
      lowest   = busy_o & (~busy_o + N'(1));
      busy_nxt = busy_o;
      if (rel_i) busy_nxt = busy_nxt & ~lowest;
      if (set_i) busy_nxt[set_idx_i] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_o <= '0;
      else        busy_o <= busy_nxt;
   end

   // R8: a claimed slot is in service on the next cycle
   a_r8_claim_marks: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> busy_o[$past(set_idx_i)]);

   // R9: a release removes exactly one in-service slot
   a_r9_release_one: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_i && !set_i && (busy_o != '0)) |=>
         ($countones(busy_o) == $countones($past(busy_o)) - 1));

   // R9: a release with nothing in service changes nothing
   a_r9_release_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_i && !set_i && (busy_o == '0)) |=> (busy_o == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
`timescale 1ns/1ps
module vec_irq_ctrl
   import vic_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 32,
   parameter int unsigned NUM_SLOT = 16,
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  irq_src_i,
   input  logic                bus_sel_i,
   input  logic                bus_wr_i,
   input  logic [7:0]          bus_addr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic                fiq_o,
   output logic                irq_o,
   output logic [ADDR_W-1:0]   vec_addr_o
);
   localparam int unsigned SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int unsigned IW = (NUM_SLOT > 1) ? $clog2(NUM_SLOT) : 1;
   localparam int unsigned EN_BIT = SW;

   // elaboration-time parameter checks
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("NUM_SRC must be between 1 and DATA_W");
   end
   if (NUM_SLOT < 1 || NUM_SLOT > 16) begin : g_bad_slot
      $error("NUM_SLOT must be between 1 and 16");
   end
   if (ADDR_W > DATA_W || EN_BIT >= DATA_W) begin : g_bad_width
      $error("ADDR_W and the slot control word must fit DATA_W");
   end

   // bus decode
   logic wr_en, rd_en;
   assign wr_en = bus_sel_i &  bus_wr_i;
   assign rd_en = bus_sel_i & ~bus_wr_i;

   // global registers
   logic [NUM_SRC-1:0] mask_q, fast_q;
   logic [ADDR_W-1:0]  dflt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         fast_q <= '0;
         dflt_q <= '0;
      end else if (wr_en) begin
         case (bus_addr_i)
            A_MASK: mask_q <= bus_wdata_i[NUM_SRC-1:0];
            A_FAST: fast_q <= bus_wdata_i[NUM_SRC-1:0];
            A_DFLT: dflt_q <= bus_wdata_i[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   // per-slot registers
   logic [SW-1:0]     sel_q   [NUM_SLOT];
   logic              en_q    [NUM_SLOT];
   logic [ADDR_W-1:0] vaddr_q [NUM_SLOT];

   for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot_regs
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q[k]   <= '0;
            en_q[k]    <= 1'b0;
            vaddr_q[k] <= '0;
         end else if (wr_en) begin
            if (bus_addr_i == {A_CTRL_PAGE, 4'(k)}) begin
               sel_q[k] <= bus_wdata_i[SW-1:0];
               en_q[k]  <= bus_wdata_i[EN_BIT];
            end
            if (bus_addr_i == {A_ADDR_PAGE, 4'(k)}) begin
               vaddr_q[k] <= bus_wdata_i[ADDR_W-1:0];
            end
         end
      end
   end

   // classification of each source line
   logic [NUM_SRC-1:0] masked, fast_req, vect_cand, plain_req;
   src_class_e         cls [NUM_SRC];

   assign masked = irq_src_i & mask_q;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_class
      logic claimed;
      always_comb begin
         claimed = 1'b0;
         for (int k = 0; k < NUM_SLOT; k++) begin
            if (en_q[k] && (32'(sel_q[k]) == i)) claimed = 1'b1;
         end
         if (fast_q[i])    cls[i] = CLS_FAST;
         else if (claimed) cls[i] = CLS_VECT;
         else              cls[i] = CLS_PLAIN;
      end
      assign fast_req[i]  = masked[i] && (cls[i] == CLS_FAST);
      assign vect_cand[i] = masked[i] && (cls[i] == CLS_VECT);
      assign plain_req[i] = masked[i] && (cls[i] == CLS_PLAIN);
   end

   // slot matching
   logic [NUM_SLOT-1:0] slot_hit;
   for (genvar k = 0; k < NUM_SLOT; k++) begin : g_match
      vic_slot_match #(.NUM_SRC(NUM_SRC), .SW(SW)) u_match (
         .en_i   (en_q[k]),
         .sel_i  (sel_q[k]),
         .cand_i (vect_cand),
         .hit_o  (slot_hit[k])
      );
   end

   // priority with in-service blocking
   logic [NUM_SLOT-1:0] busy, grant;
   logic [IW-1:0]       win_idx;
   logic                win_valid;
   logic                claim, release_eoi;

   vic_prio_pick #(.N(NUM_SLOT), .IW(IW)) u_pick (
      .act_i   (slot_hit),
      .busy_i  (busy),
      .grant_o (grant),
      .idx_o   (win_idx),
      .valid_o (win_valid)
   );

   assign claim       = rd_en && (bus_addr_i == A_VEC) && win_valid;
   assign release_eoi = wr_en && (bus_addr_i == A_EOI);

   vic_inservice #(.N(NUM_SLOT), .IW(IW)) u_isr (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (claim),
      .set_idx_i (win_idx),
      .rel_i     (release_eoi),
      .busy_o    (busy)
   );

   // outputs
   assign fiq_o      = |fast_req;
   assign irq_o      = |(vect_cand | plain_req);
   assign vec_addr_o = win_valid ? vaddr_q[win_idx] : dflt_q;

   // read mux and registered read data
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      case (bus_addr_i)
         A_RAW:   rd_mux = DATA_W'(irq_src_i);
         A_MASK:  rd_mux = DATA_W'(mask_q);
         A_FAST:  rd_mux = DATA_W'(fast_q);
         A_FSTAT: rd_mux = DATA_W'(fast_req);
         A_MSTAT: rd_mux = DATA_W'(masked);
         A_DFLT:  rd_mux = DATA_W'(dflt_q);
         A_VEC:   rd_mux = DATA_W'(vec_addr_o);
         default: begin
            for (int k = 0; k < NUM_SLOT; k++) begin
               if (bus_addr_i == {A_CTRL_PAGE, 4'(k)})
                  rd_mux = DATA_W'({en_q[k], sel_q[k]});
               if (bus_addr_i == {A_ADDR_PAGE, 4'(k)})
                  rd_mux = DATA_W'(vaddr_q[k]);
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     bus_rdata_o <= '0;
      else if (rd_en) bus_rdata_o <= rd_mux;
   end

   // R2: with every line masked, neither output can be raised
   a_r2_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> (!fiq_o && !irq_o));

   // R3/R5: when only fast-class lines request, irq_o stays low
   a_r3_fast_not_normal: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_src_i & mask_q & ~fast_q) == '0) |-> !irq_o);

   // R6: a granted slot never points at a fast-class source
   a_r6_grant_not_fast: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> !fast_q[sel_q[win_idx]]);

   // R7: at most one slot wins, and never one in service
   a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant) && ((grant & busy) == '0));

   // R8: an empty vector read leaves the in-service set alone
   a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (bus_addr_i == A_VEC) && !win_valid && !release_eoi) |=> $stable(busy));

   // R10: read data holds while no read is made
   a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(bus_rdata_o));
endmodule

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src = '0;
   logic        sel = 1'b0, wr = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        fiq, irq;
   logic [31:0] vaddr;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   vec_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .irq_src_i(src),
      .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .fiq_o(fiq), .irq_o(irq), .vec_addr_o(vaddr)
   );

   localparam logic [31:0] DFLT = 32'hDEAD_0000;

   function automatic int slot_src(input int k);
      return (3 * k + 1) % 32;
   endfunction
   function automatic logic [31:0] slot_addr(input int k);
      return 32'h1000 + 32'(4 * k);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_w(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_r(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic drive(input logic [31:0] v);
      @(negedge clk);
      src = v;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] all_slots;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 fiq", {31'b0, fiq}, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      bus_r(8'h01, d); chk("R1 mask", d, 0);
      bus_r(8'h05, d); chk("R1 default", d, 0);
      bus_r(8'h10, d); chk("R1 slot ctrl", d, 0);

      // R2 masking and raw/masked status
      drive('1);
      chk("R2 masked irq", {31'b0, irq}, 0);
      bus_r(8'h00, d); chk("R2 raw", d, 32'hFFFF_FFFF);
      bus_r(8'h04, d); chk("R2 masked status", d, 0);
      bus_w(8'h01, 32'hFFFF_FFFF);
      bus_r(8'h04, d); chk("R2 masked status open", d, 32'hFFFF_FFFF);
      chk("R5 irq all open", {31'b0, irq}, 1);

      // R3/R4/R5/R2 sweep over every line
      for (int i = 0; i < 32; i++) begin
         bus_w(8'h02, 32'(1) << i);
         drive(32'(1) << i);
         chk("R3 fiq on fast line", {31'b0, fiq}, 1);
         chk("R3 irq off for fast line", {31'b0, irq}, 0);
         bus_r(8'h03, d); chk("R4 fast status", d, 32'(1) << i);
         drive(~(32'(1) << i));
         chk("R3 fiq off", {31'b0, fiq}, 0);
         chk("R5 irq from others", {31'b0, irq}, 1);
         bus_r(8'h03, d); chk("R4 fast status idle", d, 0);
         bus_w(8'h01, ~(32'(1) << i));
         drive(32'(1) << i);
         chk("R2 masked fast line", {31'b0, fiq}, 0);
         bus_w(8'h01, 32'hFFFF_FFFF);
      end
      bus_w(8'h02, 0);

      // R6/R10 slot programming and readback
      for (int k = 0; k < 16; k++) begin
         bus_w(8'h10 + 8'(k), 32'h20 | 32'(slot_src(k)));
         bus_w(8'h20 + 8'(k), slot_addr(k));
      end
      bus_w(8'h05, DFLT);
      bus_r(8'h13, d); chk("R10 slot ctrl readback", d, 32'h20 | 32'(slot_src(3)));
      bus_r(8'h23, d); chk("R10 slot addr readback", d, slot_addr(3));
      bus_r(8'h05, d); chk("R10 default readback", d, DFLT);

      // R7 single slot, pairs, and descending removal
      all_slots = '0;
      for (int k = 0; k < 16; k++) all_slots |= 32'(1) << slot_src(k);
      for (int k = 0; k < 16; k++) begin
         logic [31:0] upper;
         drive(32'(1) << slot_src(k));
         chk("R7 single slot", vaddr, slot_addr(k));
         chk("R5 irq vectored", {31'b0, irq}, 1);
         if (k < 15) begin
            drive((32'(1) << slot_src(k)) | (32'(1) << slot_src(k + 1)));
            chk("R7 pair priority", vaddr, slot_addr(k));
         end
         upper = '0;
         for (int j = k; j < 16; j++) upper |= 32'(1) << slot_src(j);
         drive(upper);
         chk("R7 highest of many", vaddr, slot_addr(k));
      end
      drive(32'h1);
      chk("R7 unclaimed line gives default", vaddr, DFLT);
      chk("R5 irq non-vectored", {31'b0, irq}, 1);
      drive('0);
      chk("R7 idle gives default", vaddr, DFLT);

      // R6 disabled slot
      bus_w(8'h13, 32'(slot_src(3)));
      drive(32'(1) << slot_src(3));
      chk("R6 disabled slot", vaddr, DFLT);
      chk("R6 disabled slot irq", {31'b0, irq}, 1);
      bus_w(8'h13, 32'h20 | 32'(slot_src(3)));
      chk("R6 re-enabled slot", vaddr, slot_addr(3));

      // R6 fast-class source on a slot
      bus_w(8'h02, 32'(1) << slot_src(0));
      drive(32'(1) << slot_src(0));
      chk("R6 fast source no vector", vaddr, DFLT);
      chk("R6 fast source fiq", {31'b0, fiq}, 1);
      chk("R6 fast source no irq", {31'b0, irq}, 0);
      drive((32'(1) << slot_src(0)) | (32'(1) << slot_src(1)));
      chk("R6 next slot wins", vaddr, slot_addr(1));
      bus_w(8'h02, 0);

      // R8/R9 claim, nesting, release
      drive((32'(1) << slot_src(5)) | (32'(1) << slot_src(9)));
      chk("R8 presented before claim", vaddr, slot_addr(5));
      bus_r(8'h06, d); chk("R8 read returns winner", d, slot_addr(5));
      #1;
      chk("R8 claimed slot hides lower", vaddr, DFLT);
      drive((32'(1) << slot_src(5)) | (32'(1) << slot_src(9)) | (32'(1) << slot_src(2)));
      chk("R8 higher slot preempts", vaddr, slot_addr(2));
      bus_r(8'h06, d); chk("R8 nested read", d, slot_addr(2));
      #1;
      chk("R8 nested claim hides", vaddr, DFLT);
      bus_w(8'h07, 0);
      #1;
      chk("R9 release innermost", vaddr, slot_addr(2));
      drive((32'(1) << slot_src(5)) | (32'(1) << slot_src(9)));
      chk("R9 slot5 still held", vaddr, DFLT);
      bus_w(8'h07, 0);
      #1;
      chk("R9 release outer", vaddr, slot_addr(5));
      bus_w(8'h07, 0);
      #1;
      chk("R9 release when empty", vaddr, slot_addr(5));

      // R8 empty read marks nothing
      drive('0);
      bus_r(8'h06, d); chk("R8 empty read default", d, DFLT);
      drive(32'(1) << slot_src(9));
      chk("R8 empty read left nothing held", vaddr, slot_addr(9));

      // R10 read data holds without a read
      bus_r(8'h05, d);
      repeat (3) @(negedge clk);
      chk("R10 rdata hold", rdata, DFLT);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule